// File: doc/BRIEF.md
# HDLC Interrupt Source and Masking Controller

This block collects events from an HDLC transmitter, an HDLC receiver and the receive status logic, and turns them into one interrupt line for a microcontroller. It keeps three sticky source bits: new status, receive ready and transmit ready. Each source bit is cleared only as a side effect of a particular register access: a status read, a receive-data read or a transmit-data write. Writing the source register has no effect on it. A per-bit enable mask decides which status events raise new status, and a global enable gates the interrupt pin.

Two small state machines hold the receive and transmit handshakes. The receive machine has the states RX_EMPTY and RX_FULL. It moves RX_EMPTY→RX_FULL on a data byte, stays in RX_FULL on a further data byte (which is an overrun), and returns RX_FULL→RX_EMPTY on a receive-data read when no byte arrives in the same cycle. The transmit machine has the states TX_WAIT and TX_READY. It moves TX_WAIT→TX_READY when a byte starts to be sent while a transmit-control bit is set, and returns TX_READY→TX_WAIT on a transmit-data write when no such start happens in the same cycle. Both machines reset to their first state.

The register port is byte wide. Register addresses: 0 control (bit 0 is the global enable), 1 status enable (bits 3:0), 2 status (read only), 3 interrupt source (read only), 4 receive data (read only), 5 transmit data, 6 transmit control (bits 3:0). Status bits: 0 flag seen, 1 abort seen, 2 idle seen, 3 receive overrun. Receive event kind codes: 0 data, 1 flag, 2 abort, 3 idle.

Top module: `hdlc_irq_ctrl`

## Requirements
- R1: After reset the source register reads 00h, the interrupt is low and the transmit and receive machines are in TX_WAIT and RX_EMPTY.
- R2: The source register reads bit 2 new status, bit 1 receive ready, bit 0 transmit ready, and zeros in bits 7:3. A write to address 3 changes nothing.
- R3: A status event whose enable bit is 1 sets new status. A status read returns the status bits, then clears them and new status.
- R4: When enable bit 0 is 0, a flag event sets status bit 0 but does not set new status and does not raise the interrupt.
- R5: A data event (kind 0) loads its byte into receive data and sets receive ready. A receive-data read returns that byte and clears receive ready.
- R6: Flag, abort and idle events (kinds 1, 2, 3) never load receive data and never set receive ready. They set status bits 0, 1 and 2.
- R7: A byte start sets transmit ready only when transmit-control bits 3:0 are not all zero. A transmit-data write clears it and drives the written byte on `tx_byte_out`.
- R8: `irq` is high exactly when control bit 0 is 1 and at least one source bit is set.
- R9: When a set event and its clearing access fall in the same cycle, the bit stays set.
- R10: A data event that arrives while receive ready is set sets status bit 3 (overrun).
- R11: Read data appears one clock edge after the read strobe and holds the value from before the read's clearing side effect. That side effect takes effect on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_evt_valid | input | 1 | Receive event pulse |
| rx_evt_kind | input | 2 | Receive event kind: 0 data, 1 flag, 2 abort, 3 idle |
| rx_evt_byte | input | 8 | Received byte for data events |
| tx_byte_start | input | 1 | First bit of a data, flag or idle byte is being sent |
| tx_byte_out | output | 8 | Transmit data register to the framer |
| irq | output | 1 | Interrupt request |

## Verification
Every source bit, status bit and the interrupt line change on the first clock edge after the event or access cycle. Read data is registered on the edge after the strobe. The bench drives all inputs on falling edges, holds each for one cycle, and samples at the next falling edge, so each result is checked exactly one edge after its cause. In the same-cycle cases, the read data taken at that sample shows the value from before the clear, and a following read shows the bit that survived.

// File: rtl/hdlc_irq_pkg.sv
package hdlc_irq_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned STAT_W = 4;
    localparam int unsigned TXC_W  = 4;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] A_SRC  = 3'd3;
    localparam logic [ADDR_W-1:0] A_RXD  = 3'd4;
    localparam logic [ADDR_W-1:0] A_TXD  = 3'd5;
    localparam logic [ADDR_W-1:0] A_TXC  = 3'd6;

    localparam int unsigned ST_FLAG    = 0;
    localparam int unsigned ST_ABORT   = 1;
    localparam int unsigned ST_IDLE    = 2;
    localparam int unsigned ST_OVERRUN = 3;

    typedef enum logic [1:0] {
        EVT_DATA  = 2'd0,
        EVT_FLAG  = 2'd1,
        EVT_ABORT = 2'd2,
        EVT_IDLE  = 2'd3
    } rx_kind_e;

    typedef enum logic {
        RX_EMPTY = 1'b0,
        RX_FULL  = 1'b1
    } rx_state_e;

    typedef enum logic {
        TX_WAIT  = 1'b0,
        TX_READY = 1'b1
    } tx_state_e;

endpackage

// File: rtl/hdlc_irq_rx.sv
module hdlc_irq_rx
    import hdlc_irq_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned SW = STAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_valid,
    input  rx_kind_e      evt_kind,
    input  logic [DW-1:0] evt_byte,
    input  logic          rd_rxd,
    output logic          rx_ready,
    output logic [DW-1:0] rx_data,
    output logic [SW-1:0] evt_status
);

    rx_state_e state_q, state_d;
    logic      data_evt;

    assign data_evt = evt_valid && (evt_kind == EVT_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (data_evt) state_d = RX_FULL;
            RX_FULL:  if (rd_rxd && !data_evt) state_d = RX_EMPTY;
            default:  state_d = RX_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rx_data <= '0;
        else if (data_evt) rx_data <= evt_byte;
    end

    always_comb begin
        evt_status             = '0;
        evt_status[ST_FLAG]    = evt_valid && (evt_kind == EVT_FLAG);
        evt_status[ST_ABORT]   = evt_valid && (evt_kind == EVT_ABORT);
        evt_status[ST_IDLE]    = evt_valid && (evt_kind == EVT_IDLE);
        evt_status[ST_OVERRUN] = data_evt && (state_q == RX_FULL);
    end

    assign rx_ready = (state_q == RX_FULL);

    a_r5_data_loads: assert property (@(posedge clk) disable iff (!rst_n)
        data_evt |=> (rx_ready && rx_data == $past(evt_byte)));

    a_r6_nondata_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind != EVT_DATA) |=> $stable(rx_data));

    a_r9_rx_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxd && data_evt) |=> rx_ready);

endmodule

// File: rtl/hdlc_irq_tx.sv
module hdlc_irq_tx
    import hdlc_irq_pkg::*;
#(
    parameter int unsigned CW = TXC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_start,
    input  logic [CW-1:0] txc,
    input  logic          wr_txd,
    output logic          tx_ready
);

    tx_state_e state_q, state_d;
    logic      arm;

    assign arm = byte_start && (txc != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_WAIT:  if (arm) state_d = TX_READY;
            TX_READY: if (wr_txd && !arm) state_d = TX_WAIT;
            default:  state_d = TX_WAIT;
        endcase
    end

    assign tx_ready = (state_q == TX_READY);

    a_r7_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> tx_ready);

    a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_txd && !arm) |=> !tx_ready);

    a_r7_no_ctrl_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && txc == '0) |=> !tx_ready);

endmodule

// File: rtl/hdlc_irq_status.sv
module hdlc_irq_status
    import hdlc_irq_pkg::*;
#(
    parameter int unsigned SW = STAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] set_vec,
    input  logic [SW-1:0] ien,
    input  logic          rd_stat,
    output logic [SW-1:0] status,
    output logic          new_stat
);

    logic [SW-1:0] keep_mask;
    logic          hit;

    assign keep_mask = rd_stat ? '0 : '1;
    assign hit       = |(set_vec & ien);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status   <= '0;
            new_stat <= 1'b0;
        end else begin
            status   <= (status & keep_mask) | set_vec;
            new_stat <= (new_stat && !rd_stat) || hit;
        end
    end

    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && set_vec == '0) |=> (status == '0 && !new_stat));

    a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!new_stat && (set_vec & ien) == '0) |=> !new_stat);

    a_r9_stat_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && (set_vec & ien) != '0) |=> new_stat);

endmodule

// File: rtl/hdlc_irq_regs.sv
module hdlc_irq_regs
    import hdlc_irq_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned SW = STAT_W,
    parameter int unsigned CW = TXC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [SW-1:0] status,
    input  logic          new_stat,
    input  logic          rx_ready,
    input  logic          tx_ready,
    input  logic [DW-1:0] rx_data,
    output logic          ctrl_en,
    output logic [SW-1:0] ien,
    output logic [CW-1:0] txc,
    output logic [DW-1:0] txd,
    output logic          rd_stat,
    output logic          rd_rxd,
    output logic          wr_txd
);

    localparam int unsigned SRC_W = 3;

    logic [DW-1:0] rd_mux;

    assign rd_stat = bus_rd && (bus_addr == A_STAT);
    assign rd_rxd  = bus_rd && (bus_addr == A_RXD);
    assign wr_txd  = bus_wr && (bus_addr == A_TXD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            ien     <= '0;
            txc     <= '0;
            txd     <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_CTRL:  ctrl_en <= bus_wdata[0];
                A_IEN:   ien     <= bus_wdata[SW-1:0];
                A_TXD:   txd     <= bus_wdata;
                A_TXC:   txc     <= bus_wdata[CW-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            A_CTRL:  rd_mux = {{(DW-1){1'b0}}, ctrl_en};
            A_IEN:   rd_mux = {{(DW-SW){1'b0}}, ien};
            A_STAT:  rd_mux = {{(DW-SW){1'b0}}, status};
            A_SRC:   rd_mux = {{(DW-SRC_W){1'b0}}, new_stat, rx_ready, tx_ready};
            A_RXD:   rd_mux = rx_data;
            A_TXD:   rd_mux = txd;
            A_TXC:   rd_mux = {{(DW-CW){1'b0}}, txc};
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    a_r2_src_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_SRC) |=> (bus_rdata[DW-1:SRC_W] == '0));

    a_r11_rxd_pre_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rxd |=> (bus_rdata == $past(rx_data)));

    a_r8_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTRL) |=> (ctrl_en == $past(bus_wdata[0])));

endmodule

// File: rtl/hdlc_irq_ctrl.sv
module hdlc_irq_ctrl
    import hdlc_irq_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned SW = STAT_W,
    parameter int unsigned CW = TXC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          rx_evt_valid,
    input  logic [1:0]    rx_evt_kind,
    input  logic [DW-1:0] rx_evt_byte,
    input  logic          tx_byte_start,
    output logic [DW-1:0] tx_byte_out,
    output logic          irq
);

    logic          ctrl_en, new_stat, rx_ready, tx_ready;
    logic          rd_stat, rd_rxd, wr_txd;
    logic [SW-1:0] ien, status, evt_status;
    logic [CW-1:0] txc;
    logic [DW-1:0] rx_data;
    rx_kind_e      kind;

    assign kind = rx_kind_e'(rx_evt_kind);

    hdlc_irq_regs #(.DW(DW), .AW(AW), .SW(SW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .status(status), .new_stat(new_stat), .rx_ready(rx_ready),
        .tx_ready(tx_ready), .rx_data(rx_data),
        .ctrl_en(ctrl_en), .ien(ien), .txc(txc), .txd(tx_byte_out),
        .rd_stat(rd_stat), .rd_rxd(rd_rxd), .wr_txd(wr_txd)
    );

    hdlc_irq_rx #(.DW(DW), .SW(SW)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(rx_evt_valid), .evt_kind(kind), .evt_byte(rx_evt_byte),
        .rd_rxd(rd_rxd), .rx_ready(rx_ready), .rx_data(rx_data),
        .evt_status(evt_status)
    );

    hdlc_irq_tx #(.CW(CW)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .byte_start(tx_byte_start), .txc(txc), .wr_txd(wr_txd),
        .tx_ready(tx_ready)
    );

    hdlc_irq_status #(.SW(SW)) u_status (
        .clk(clk), .rst_n(rst_n),
        .set_vec(evt_status), .ien(ien), .rd_stat(rd_stat),
        .status(status), .new_stat(new_stat)
    );

    assign irq = ctrl_en && (new_stat || rx_ready || tx_ready);

    a_r8_rx_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt_valid && kind == EVT_DATA && ctrl_en &&
         !(bus_wr && bus_addr == A_CTRL)) |=> irq);

    a_r10_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt_valid && kind == EVT_DATA && rx_ready) |=> status[ST_OVERRUN]);

endmodule

// File: tb/test_hdlc_irq_ctrl.sv
module test_hdlc_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_evt_valid = 1'b0;
    logic [1:0] rx_evt_kind = '0;
    logic [7:0] rx_evt_byte = '0;
    logic       tx_byte_start = 1'b0;
    logic [7:0] tx_byte_out;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    hdlc_irq_ctrl i_hdlc_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_evt_valid(rx_evt_valid), .rx_evt_kind(rx_evt_kind),
        .rx_evt_byte(rx_evt_byte), .tx_byte_start(tx_byte_start),
        .tx_byte_out(tx_byte_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rx(input logic [1:0] k, input logic [7:0] b);
        rx_evt_valid = 1'b1; rx_evt_kind = k; rx_evt_byte = b;
        @(negedge clk);
        rx_evt_valid = 1'b0;
    endtask

    task automatic tx_start();
        tx_byte_start = 1'b1;
        @(negedge clk);
        tx_byte_start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] last_byte;
        logic       ns, rr;
        last_byte = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {7'b0, irq}, 8'h00);
        rd(3'd3, d); chk("R1 source", d, 8'h00);

        // R2 write to source register ignored
        wr(3'd3, 8'hFF);
        rd(3'd3, d); chk("R2 source write ignored", d, 8'h00);

        // R3 R4 R6 R8 R10 sweep: enable mask x event kind x global enable
        for (int en = 0; en < 16; en++) begin
            for (int k = 0; k < 4; k++) begin
                for (int g = 0; g < 2; g++) begin
                    wr(3'd0, 8'(g));
                    wr(3'd1, 8'(en));
                    rd(3'd4, d); chk("R6 rx data unchanged", d, last_byte);
                    rd(3'd2, d);
                    if (k < 3) begin
                        rx(2'(k + 1), 8'hEE);
                    end else begin
                        rx(2'd0, 8'(en * 8 + g));
                        rx(2'd0, 8'(en * 8 + g + 128));
                        last_byte = 8'(en * 8 + g + 128);
                    end
                    ns = en[k];
                    rr = (k == 3);
                    chk(k == 0 ? "R4 irq" : "R8 irq", {7'b0, irq},
                        {7'b0, (g == 1) && (ns || rr)});
                    rd(3'd3, d);
                    chk(k == 0 ? "R4 source" : "R3 source", d, {5'b0, ns, rr, 1'b0});
                    rd(3'd2, d);
                    chk(k == 3 ? "R10 overrun status" : "R6 status", d, 8'(1 << k));
                    rd(3'd3, d);
                    chk("R3 status read clears", d, {5'b0, 1'b0, rr, 1'b0});
                end
            end
        end
        rd(3'd4, d); chk("R5 rx read", d, last_byte);
        rd(3'd3, d); chk("R5 rx ready cleared", d, 8'h00);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);

        // R7 sweep over transmit-control values
        for (int c = 0; c < 16; c++) begin
            wr(3'd6, 8'(c));
            tx_start();
            rd(3'd3, d); chk("R7 tx ready set", d, {7'b0, c != 0});
            wr(3'd5, 8'(c * 16 + 1));
            chk("R7 tx byte out", tx_byte_out, 8'(c * 16 + 1));
            rd(3'd3, d); chk("R7 tx ready cleared", d, 8'h00);
        end

        // R8 irq from transmit ready, global enable toggling
        wr(3'd6, 8'h08);
        tx_start();
        chk("R8 irq gated", {7'b0, irq}, 8'h00);
        wr(3'd0, 8'h01);
        chk("R8 irq enabled", {7'b0, irq}, 8'h01);
        wr(3'd5, 8'h00);
        chk("R8 irq drops", {7'b0, irq}, 8'h00);
        wr(3'd0, 8'h00);

        // R9 R11 receive read and data arrival in the same cycle
        rx(2'd0, 8'h11);
        bus_addr = 3'd4; bus_rd = 1'b1;
        rx_evt_valid = 1'b1; rx_evt_kind = 2'd0; rx_evt_byte = 8'h5A;
        @(negedge clk);
        bus_rd = 1'b0; rx_evt_valid = 1'b0;
        chk("R11 read returns pre-clear byte", bus_rdata, 8'h11);
        rd(3'd3, d); chk("R9 rx ready survives", d, 8'h02);
        rd(3'd4, d); chk("R5 new byte", d, 8'h5A);
        rd(3'd2, d); chk("R10 overrun", d, 8'h08);
        rd(3'd3, d); chk("R5 empty", d, 8'h00);

        // R9 transmit write and byte start in the same cycle
        wr(3'd6, 8'h01);
        tx_start();
        bus_addr = 3'd5; bus_wdata = 8'h33; bus_wr = 1'b1; tx_byte_start = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tx_byte_start = 1'b0;
        rd(3'd3, d); chk("R9 tx ready survives", d, 8'h01);
        chk("R7 tx byte", tx_byte_out, 8'h33);
        wr(3'd5, 8'h44);
        rd(3'd3, d); chk("R7 tx cleared", d, 8'h00);

        // R9 R11 status read and flag event in the same cycle
        wr(3'd1, 8'h01);
        rx(2'd1, 8'h00);
        bus_addr = 3'd2; bus_rd = 1'b1;
        rx_evt_valid = 1'b1; rx_evt_kind = 2'd1;
        @(negedge clk);
        bus_rd = 1'b0; rx_evt_valid = 1'b0;
        chk("R11 status pre-clear", bus_rdata, 8'h01);
        rd(3'd3, d); chk("R9 new status survives", d, 8'h04);
        rd(3'd2, d); chk("R9 status flag survives", d, 8'h01);
        rd(3'd3, d); chk("R3 cleared", d, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule